// File: doc/BRIEF.md
# Nested address translation walker

This block turns a guest-physical address into a host-physical address. It walks a four-level second-stage page table that sits in ordinary memory. A request carries the guest-physical address and an access kind (read, write or instruction fetch). The walker also samples a table-pointer register, which gives the root table location, a memory-type field, a walk-length field and a flag-update enable. Each table holds 512 entries of 64 bits, so each level resolves 9 address bits above the 12-bit page offset.

The walker reads one entry per level through a single-outstanding memory port. It checks that the entry is present and that its permission bits allow the access. A second-level or third-level entry with its size bit set ends the walk early as a 1 GiB or 2 MiB mapping. While it walks, the walker sets the sticky accessed flag in every entry it uses. On writes it also sets the dirty flag in the final mapping entry. Each of these updates is a read-modify-write back to the same entry address.

The result comes back as a one-cycle done pulse. The pulse carries either the host-physical address or a violation flag. The walker handles one request at a time.

Top module: `s2_walker`

## Requirements
- R1: A request whose pointer has memory type (bits 2:0) other than 6, or walk length (bits 5:3) other than 3, or any of bits 11:7 set, completes as a violation without any memory access, with done one cycle after acceptance.
- R2: The root table base is pointer bits PA_W-1:12 times 4096. Entries are read in the order of index bits 47:39, 38:30, 29:21 and 20:12. Each entry address is its table base plus index times 8, and the next base is entry bits PA_W-1:12 times 4096.
- R3: Entry bits 0, 1 and 2 grant read, write and fetch. The access code is 0 for read, 1 for write and 2 for fetch. Every entry on the path must grant the access. An entry with bits 2:0 all clear is not present. Either failure gives a violation and a host address of zero.
- R4: A second-read (bits 38:30) entry with bit 7 set maps 1 GiB. The result is entry bits PA_W-1:30 joined with guest bits 29:0.
- R5: A third-read (bits 29:21) entry with bit 7 set maps 2 MiB. The result is entry bits PA_W-1:21 joined with guest bits 20:0.
- R6: The fourth-read entry maps 4 KiB. The result is entry bits PA_W-1:12 joined with guest bits 11:0. Bit 7 has no effect in the root-level entry or the fourth-read entry.
- R7: With pointer bit 6 set, each entry that passes its checks gets accessed bit 8 set. The entry is written back to the address it was read from only when a flag changes.
- R8: On a write access with pointer bit 6 set, dirty bit 9 is set in the entry that produces the final address: a 4 KiB, 2 MiB or 1 GiB leaf.
- R9: Write-back data equals the entry as read, with bits 8 and/or 9 set. No bit is ever cleared.
- R10: With pointer bit 6 clear, no write is issued. No write is ever issued for an entry that causes a violation.
- R11: Ready is high when idle. Ready is low from acceptance until a one-cycle done pulse. A memory request holds its address and direction until acknowledged, and read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, accepted while ready |
| req_gpa_i | input | 48 | Guest-physical address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| tbl_ptr_i | input | PA_W | Table-pointer register value |
| req_ready_o | output | 1 | Idle, can accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| done_hpa_o | output | PA_W | Host-physical address (zero on violation) |
| done_viol_o | output | 1 | Violation flag, valid with done |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Request is an entry write-back |
| mem_addr_o | output | PA_W | Entry byte address |
| mem_wdata_o | output | 64 | Write-back entry value |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 64 | Entry read data |

## Verification
The bench builds the walker with its default parameters: 40-bit host addresses, four levels of 9-bit indices and a 12-bit offset. With 40-bit host addresses, a 1 GiB leaf can sit above 4 GiB, so all three leaf sizes and their offset splits can be checked against exact host addresses. A sparse bench memory holds one small table tree, reloaded before each walk. This makes the write-back count, the read address order and the stored flag bits exact per request, including the cases where a flag is already set or a violating entry must stay untouched.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  localparam int unsigned BIT_R     = 0;
  localparam int unsigned BIT_W     = 1;
  localparam int unsigned BIT_X     = 2;
  localparam int unsigned BIT_LARGE = 7;
  localparam int unsigned BIT_ACC   = 8;
  localparam int unsigned BIT_DIRTY = 9;

  localparam int unsigned PTR_AD_BIT = 6;
  localparam logic [2:0]  MT_WB      = 3'd6;
  localparam int unsigned ENT_W      = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WB, ST_FIN} wst_e;
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFS_W  = 12,
  localparam int unsigned GPA_W  = OFS_W + LEVELS * IDX_W,
  localparam int unsigned BASE_W = PA_W - OFS_W,
  localparam int unsigned LVL_W  = $clog2(LEVELS)
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [GPA_W-1:0]  gpa_i,
  output logic [PA_W-1:0]   addr_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int l = 0; l < int'(LEVELS); l++) begin
      if (lvl_i == LVL_W'(l)) idx = gpa_i[OFS_W + l*IDX_W +: IDX_W];
    end
  end

  // index * 8 stays inside the 4 KiB table, so concatenation equals the add
  assign addr_o = {base_i, {(OFS_W-IDX_W-3){1'b0}}, idx, 3'b000};
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval
  import xw_pkg::*;
#(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFS_W  = 12,
  localparam int unsigned BASE_W = PA_W - OFS_W,
  localparam int unsigned LVL_W  = $clog2(LEVELS),
  localparam int unsigned LOW_W  = OFS_W + (LEVELS-2) * IDX_W
) (
  input  logic [ENT_W-1:0]  ent_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [1:0]        acc_i,
  input  logic              ad_en_i,
  input  logic [LOW_W-1:0]  gpa_lo_i,
  output logic              viol_o,
  output logic              leaf_o,
  output logic              wb_o,
  output logic [ENT_W-1:0]  upd_o,
  output logic [PA_W-1:0]   hpa_o,
  output logic [BASE_W-1:0] nxt_base_o
);
  logic            present, perm_ok, large_ok;
  logic [PA_W-1:0] mask, ent_pa;

  always_comb begin
    present = |ent_i[BIT_X:BIT_R];
    unique case (acc_i)
      ACC_RD:  perm_ok = ent_i[BIT_R];
      ACC_WR:  perm_ok = ent_i[BIT_W];
      ACC_FX:  perm_ok = ent_i[BIT_X];
      default: perm_ok = 1'b0;
    endcase
    large_ok = (lvl_i != '0) && (int'(lvl_i) <= int'(LEVELS) - 2);
    leaf_o   = (lvl_i == '0) || (ent_i[BIT_LARGE] && large_ok);
    viol_o   = !present || !perm_ok;

    upd_o = ent_i;
    if (ad_en_i) begin
      upd_o[BIT_ACC] = 1'b1;
      if (leaf_o && acc_i == ACC_WR) upd_o[BIT_DIRTY] = 1'b1;
    end
    wb_o = !viol_o && (upd_o != ent_i);

    mask = '0;
    for (int l = 0; l <= int'(LEVELS) - 2; l++) begin
      if (lvl_i == LVL_W'(l)) mask = (PA_W'(1) << (OFS_W + l*IDX_W)) - PA_W'(1);
    end
    ent_pa = {ent_i[PA_W-1:OFS_W], {OFS_W{1'b0}}};
    hpa_o  = (ent_pa & ~mask) | (PA_W'(gpa_lo_i) & mask);
  end

  assign nxt_base_o = ent_i[PA_W-1:OFS_W];
endmodule

// File: rtl/s2_walker.sv
module s2_walker
  import xw_pkg::*;
#(
  parameter int unsigned PA_W   = 40,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFS_W  = 12,
  localparam int unsigned GPA_W  = OFS_W + LEVELS * IDX_W,
  localparam int unsigned BASE_W = PA_W - OFS_W,
  localparam int unsigned LVL_W  = $clog2(LEVELS),
  localparam int unsigned LOW_W  = OFS_W + (LEVELS-2) * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [GPA_W-1:0]  req_gpa_i,
  input  logic [1:0]        req_acc_i,
  input  logic [PA_W-1:0]   tbl_ptr_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [PA_W-1:0]   done_hpa_o,
  output logic              done_viol_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [ENT_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [ENT_W-1:0]  mem_rdata_i
);
  wst_e              st_q;
  logic [GPA_W-1:0]  gpa_q;
  logic [1:0]        acc_q;
  logic              ad_en_q, leaf_q, viol_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [BASE_W-1:0] base_q;
  logic [ENT_W-1:0]  ent_q;
  logic [PA_W-1:0]   hpa_q;

  logic              ptr_ok;
  logic              ev_viol, ev_leaf, ev_wb;
  logic [ENT_W-1:0]  ev_upd;
  logic [PA_W-1:0]   ev_hpa;
  logic [BASE_W-1:0] ev_nxt;

  assign ptr_ok = (tbl_ptr_i[2:0] == MT_WB) && (tbl_ptr_i[5:3] == 3'(LEVELS-1))
               && (tbl_ptr_i[11:7] == '0);

  xw_addr_gen #(.PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_addr (
    .base_i (base_q),
    .lvl_i  (lvl_q),
    .gpa_i  (gpa_q),
    .addr_o (mem_addr_o)
  );

  xw_entry_eval #(.PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_eval (
    .ent_i      (mem_rdata_i),
    .lvl_i      (lvl_q),
    .acc_i      (acc_q),
    .ad_en_i    (ad_en_q),
    .gpa_lo_i   (gpa_q[LOW_W-1:0]),
    .viol_o     (ev_viol),
    .leaf_o     (ev_leaf),
    .wb_o       (ev_wb),
    .upd_o      (ev_upd),
    .hpa_o      (ev_hpa),
    .nxt_base_o (ev_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      gpa_q   <= '0;
      acc_q   <= '0;
      ad_en_q <= 1'b0;
      leaf_q  <= 1'b0;
      viol_q  <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      ent_q   <= '0;
      hpa_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          gpa_q   <= req_gpa_i;
          acc_q   <= req_acc_i;
          ad_en_q <= tbl_ptr_i[PTR_AD_BIT];
          base_q  <= tbl_ptr_i[PA_W-1:OFS_W];
          lvl_q   <= LVL_W'(LEVELS-1);
          viol_q  <= !ptr_ok;
          hpa_q   <= '0;
          st_q    <= ptr_ok ? ST_RD : ST_FIN;
        end
        ST_RD: if (mem_ack_i) begin
          ent_q  <= ev_upd;
          leaf_q <= ev_leaf;
          if (ev_viol) begin
            viol_q <= 1'b1;
            hpa_q  <= '0;
            st_q   <= ST_FIN;
          end else begin
            if (ev_leaf) begin
              viol_q <= 1'b0;
              hpa_q  <= ev_hpa;
            end
            if (ev_wb) begin
              st_q <= ST_WB;
            end else if (ev_leaf) begin
              st_q <= ST_FIN;
            end else begin
              base_q <= ev_nxt;
              lvl_q  <= lvl_q - 1'b1;
            end
          end
        end
        ST_WB: if (mem_ack_i) begin
          if (leaf_q) begin
            st_q <= ST_FIN;
          end else begin
            base_q <= ent_q[PA_W-1:OFS_W];
            lvl_q  <= lvl_q - 1'b1;
            st_q   <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign done_hpa_o  = hpa_q;
  assign done_viol_o = viol_q;
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WB);
  assign mem_we_o    = (st_q == ST_WB);
  assign mem_wdata_o = ent_q;

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
  a_r11_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r1_bad_ptr_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && (tbl_ptr_i[2:0] != MT_WB) |=> done_o && done_viol_o);
  a_r7_wb_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> mem_addr_o == $past(mem_addr_o));
  a_r9_wb_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> ((mem_wdata_o & $past(mem_rdata_i)) == $past(mem_rdata_i))
                        && mem_wdata_o[BIT_ACC]);
  a_r10_no_wb_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> ad_en_q);
  a_r3_viol_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_viol_o |-> done_hpa_o == '0);
endmodule

// File: tb/tb_s2_walker.sv
module tb_s2_walker;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [47:0]       req_gpa = '0;
  logic [1:0]        req_acc = '0;
  logic [PA_W-1:0]   tbl_ptr = '0;
  logic              req_ready, done, done_viol, mem_req, mem_we;
  logic [PA_W-1:0]   done_hpa, mem_addr;
  logic [63:0]       mem_wdata;
  logic              mem_ack = 1'b0;
  logic [63:0]       mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [PA_W-1:0] rd_log [4];
  logic [63:0] mem [logic [PA_W-1:0]];
  logic busy_ok, timed_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  s2_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_gpa_i(req_gpa),
    .req_acc_i(req_acc), .tbl_ptr_i(tbl_ptr), .req_ready_o(req_ready), .done_o(done),
    .done_hpa_o(done_hpa), .done_viol_o(done_viol), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt = wr_cnt + 1;
        end else begin
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
          rd_cnt = rd_cnt + 1;
        end
      end
    end
  end

  localparam logic [PA_W-1:0] P_GOOD  = 40'h10005E;
  localparam logic [PA_W-1:0] P_NOAD  = 40'h10001E;
  localparam logic [PA_W-1:0] P_BADMT = 40'h100058;
  localparam logic [PA_W-1:0] P_BADWL = 40'h100056;

  typedef struct packed {
    logic [1:0]      acc;
    logic [47:0]     gpa;
    logic            viol;
    logic [PA_W-1:0] hpa;
    logic [3:0]      wr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 48'h80_0000_0123, 1'b0, 40'h00_5555_5123, 4'd4},  // R6 R7 4 KiB read
    '{2'd1, 48'h80_0000_0123, 1'b0, 40'h00_5555_5123, 4'd4},  // R8 4 KiB write
    '{2'd2, 48'h80_0000_0123, 1'b1, 40'h0,            4'd2},  // R3 no fetch right
    '{2'd0, 48'h80_756C_D456, 1'b0, 40'h01_756C_D456, 4'd2},  // R4 1 GiB read
    '{2'd1, 48'h80_756C_D456, 1'b1, 40'h0,            4'd1},  // R3 R10 1 GiB read-only
    '{2'd0, 48'h80_0021_0789, 1'b0, 40'h00_00A1_0789, 4'd2},  // R5 2 MiB read, flags preset
    '{2'd1, 48'h80_0021_0789, 1'b0, 40'h00_00A1_0789, 4'd2},  // R9 2 MiB write, dirty preset
    '{2'd0, 48'h80_8000_0000, 1'b1, 40'h0,            4'd1},  // R3 not present
    '{2'd0, 48'h00_0000_0123, 1'b1, 40'h0,            4'd0},  // R3 root not present
    '{2'd1, 48'h80_0000_1010, 1'b1, 40'h0,            4'd3},  // R3 4 KiB read-only
    '{2'd0, 48'h80_0000_2ABC, 1'b0, 40'h00_7777_7ABC, 4'd4}   // R6 bit 7 ignored at last read
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R6";
      1: return "R8";
      3: return "R4";
      5: return "R5";
      6: return "R9";
      10: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_tables();
    mem.delete();
    mem[40'h100008] = 64'h0000_0000_0010_1007;
    mem[40'h101000] = 64'h0000_0000_0010_2007;
    mem[40'h101008] = 64'h0000_0001_4000_0081;
    mem[40'h102000] = 64'h0000_0000_0010_3003;
    mem[40'h102008] = 64'h0000_0000_00A0_0387;
    mem[40'h103000] = 64'h0000_0000_5555_5007;
    mem[40'h103008] = 64'h0000_0000_6666_6001;
    mem[40'h103010] = 64'h0000_0000_7777_7083;
  endtask

  task automatic walk(input logic [PA_W-1:0] ptr, input logic [47:0] gpa, input logic [1:0] acc);
    int n;
    @(negedge clk);
    wr_cnt = 0;
    rd_cnt = 0;
    req_valid = 1'b1;
    req_gpa = gpa;
    req_acc = acc;
    tbl_ptr = ptr;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    n = 0;
    while (!done && n < 200) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    timed_out = !done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset ready", 64'(req_ready), 64'd1);
    check("R11 reset done", 64'(done), 64'd0);
    check("R11 reset mem_req", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load_tables();
      walk(P_GOOD, VECS[i].gpa, VECS[i].acc);
      check({vtag(i), " timeout"}, 64'(timed_out), 64'd0);
      check({vtag(i), " viol"}, 64'(done_viol), 64'(VECS[i].viol));
      check({vtag(i), " hpa"}, 64'(done_hpa), 64'(VECS[i].hpa));
      check({vtag(i), " R7 write-backs"}, 64'(wr_cnt), 64'(VECS[i].wr));
      check("R11 ready low while busy", 64'(busy_ok), 64'd1);
      @(negedge clk);
      check("R11 done single cycle", 64'(done), 64'd0);
      if (i == 0) begin
        check("R2 read 0 addr", 64'(rd_log[0]), 64'h100008);
        check("R2 read 1 addr", 64'(rd_log[1]), 64'h101000);
        check("R2 read 2 addr", 64'(rd_log[2]), 64'h102000);
        check("R2 read 3 addr", 64'(rd_log[3]), 64'h103000);
        check("R7 root accessed", mem[40'h100008], 64'h10_1107);
        check("R7 leaf accessed only", mem[40'h103000], 64'h5555_5107);
      end
      if (i == 1) check("R8 leaf dirty", mem[40'h103000], 64'h5555_5307);
      if (i == 2) check("R10 violating entry untouched", mem[40'h102000], 64'h10_3003);
      if (i == 3) check("R8 1 GiB read no dirty", mem[40'h101008], 64'h1_4000_0181);
      if (i == 6) check("R9 sticky leaf unchanged", mem[40'h102008], 64'hA0_0387);
    end

    // R8 dirty on 1 GiB leaf when writable
    load_tables();
    mem[40'h101008] = 64'h0000_0001_4000_0083;
    walk(P_GOOD, 48'h80_756C_D456, 2'd1);
    check("R8 1 GiB dirty", mem[40'h101008], 64'h1_4000_0383);
    check("R4 1 GiB write hpa", 64'(done_hpa), 64'h1_756C_D456);

    // R10 flag updates disabled
    load_tables();
    walk(P_NOAD, 48'h80_0000_0123, 2'd1);
    check("R10 no write-back", 64'(wr_cnt), 64'd0);
    check("R10 hpa", 64'(done_hpa), 64'h5555_5123);
    check("R10 leaf unchanged", mem[40'h103000], 64'h5555_5007);

    // R6 bit 7 ignored at root
    load_tables();
    mem[40'h100008] = 64'h0000_0000_0010_1087;
    walk(P_GOOD, 48'h80_0000_0123, 2'd0);
    check("R6 root bit7 ignored viol", 64'(done_viol), 64'd0);
    check("R6 root bit7 ignored hpa", 64'(done_hpa), 64'h5555_5123);
    check("R9 root keeps bit7", mem[40'h100008], 64'h10_1187);

    // R1 bad pointer fields
    load_tables();
    walk(P_BADMT, 48'h80_0000_0123, 2'd0);
    check("R1 bad type viol", 64'(done_viol), 64'd1);
    check("R1 bad type no reads", 64'(rd_cnt), 64'd0);
    check("R1 bad type hpa", 64'(done_hpa), 64'd0);
    walk(P_BADWL, 48'h80_0000_0123, 2'd0);
    check("R1 bad length viol", 64'(done_viol), 64'd1);
    check("R1 bad length no reads", 64'(rd_cnt), 64'd0);
    walk(P_GOOD | 40'h80, 48'h80_0000_0123, 2'd0);
    check("R1 reserved bit viol", 64'(done_viol), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule